// File: doc/BRIEF.md
# Event Queue Producer Engine

This block appends fixed-size event records to a circular queue that lives in system memory. A source offers one record at a time on a valid/ready handshake. The block computes the slot address from a configured base and its own producer index, issues a single write on a request/response memory port, and moves the producer index only after that write comes back clean. Software drains the queue and reports its progress by updating the consumer index input. Both indices carry a wrap bit in their most significant position.

Events are never back-pressured because the queue is disabled or full. They are accepted and then silently discarded. The block raises a one-cycle interrupt pulse when a successful write turns an empty queue into a non-empty one. It reports each failed write with a one-cycle error pulse and leaves the index where it was, so the next event retries the same slot.

Top module: `evq_producer`

## Requirements
- R1: After reset, `evt_ready` is 1, `prod_idx` is 0, and `wr_req_valid`, `irq_pulse` and `wr_err_pulse` are 0.
- R2: An event accepted while `cfg_enable` is 0 produces no memory request and leaves `prod_idx` unchanged.
- R3: The queue is full when the low LOG2SIZE bits of `prod_idx` and `cons_idx` are equal and their wrap bits (bit LOG2SIZE) differ. An event accepted while the queue is full is discarded: no request is made and `prod_idx` is unchanged.
- R4: A stored event is written with `wr_req_addr` = `cfg_base` + (low LOG2SIZE bits of `prod_idx`) × 2^ENTRY_LOG2, and `wr_req_data` equal to the event record.
- R5: `prod_idx` changes only in the cycle after a response with `wr_rsp_err` = 0. A response with `wr_rsp_err` = 1 leaves `prod_idx` unchanged and gives a one-cycle `wr_err_pulse` in the next cycle.
- R6: `prod_idx` counts through 2^LOG2SIZE slots. Advancing from the last slot returns the index field to 0 and toggles the wrap bit in bit LOG2SIZE.
- R7: `evt_ready` is 0 from the acceptance of a stored event until the cycle after its write response.
- R8: `irq_pulse` is high for exactly one cycle, in the cycle after a successful response, and only if the queue was empty (both indices equal including wrap) before that write. Otherwise it stays 0.
- R9: While `wr_req_valid` is 1 and `wr_req_ready` is 0, the request stays valid and `wr_req_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Queue enable; 0 discards events |
| cfg_base | input | ADDR_W | Byte address of slot 0 |
| cons_idx | input | LOG2SIZE+1 | Consumer index, wrap bit on top |
| evt_valid | input | 1 | Event record offered |
| evt_ready | output | 1 | Block can take an event |
| evt_data | input | REC_W | Event record |
| wr_req_valid | output | 1 | Memory write request valid |
| wr_req_ready | input | 1 | Memory write request accepted |
| wr_req_addr | output | ADDR_W | Write byte address |
| wr_req_data | output | REC_W | Write data |
| wr_rsp_valid | input | 1 | Write response valid |
| wr_rsp_err | input | 1 | Write response reports failure |
| prod_idx | output | LOG2SIZE+1 | Producer index, wrap bit on top |
| irq_pulse | output | 1 | Empty-to-non-empty interrupt pulse |
| wr_err_pulse | output | 1 | Failed-write pulse |

## Verification
The hardest state to reach is a full queue whose wrap bits differ, followed by a write failure and a retry on the same slot. The bench reaches it by filling all eight slots against a fixed consumer index and offering one more event, which must be dropped. It then moves the consumer index partway, forces one error response, and checks that the retry lands at the same address. A separate phase stalls the request port to hold a write outstanding and confirm that the handshake and the address stay frozen. Another phase sets the consumer index equal to the producer index, so that the empty-to-non-empty interrupt fires a second time.

// File: rtl/evq_pkg.sv
package evq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } evq_state_e;
endpackage

// File: rtl/evq_rst_sync.sv
module evq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/evq_ptr.sv
module evq_ptr #(
  parameter int LOG2SIZE = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic [LOG2SIZE:0]   cons_idx,
  output logic [LOG2SIZE:0]   prod_idx,
  output logic                q_empty,
  output logic                q_full
);
  localparam int PW = LOG2SIZE + 1;

  logic [PW-1:0] prod_q, prod_d;

  // wrap bit sits above the index field, so a plain increment toggles it
  always_comb begin
    prod_d = prod_q;
    if (adv) prod_d = prod_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prod_q <= '0;
    else if (adv) prod_q <= prod_d;
  end

  assign q_empty  = (prod_q == cons_idx);
  assign q_full   = (prod_q[LOG2SIZE-1:0] == cons_idx[LOG2SIZE-1:0]) &&
                    (prod_q[LOG2SIZE] != cons_idx[LOG2SIZE]);
  assign prod_idx = prod_q;
endmodule

// File: rtl/evq_addr_gen.sv
module evq_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int LOG2SIZE   = 3,
  parameter int ENTRY_LOG2 = 5
) (
  input  logic [ADDR_W-1:0]   base,
  input  logic [LOG2SIZE-1:0] slot,
  output logic [ADDR_W-1:0]   addr
);
  localparam int PAD = ADDR_W - LOG2SIZE;

  logic [ADDR_W-1:0] offset;

  generate
    if (ENTRY_LOG2 == 0) begin : g_byte_slots
      assign offset = {{PAD{1'b0}}, slot};
    end else begin : g_wide_slots
      assign offset = {{PAD{1'b0}}, slot} << ENTRY_LOG2;
    end
  endgenerate

  assign addr = base + offset;
endmodule

// File: rtl/evq_ctrl.sv
module evq_ctrl
  import evq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt_valid,
  input  logic q_enable,
  input  logic q_full,
  input  logic q_empty,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic rsp_err,
  output logic evt_ready,
  output logic capture,
  output logic req_valid,
  output logic adv,
  output logic irq_pulse,
  output logic err_pulse
);
  evq_state_e st_q, st_d;
  logic       irq_q, irq_d;
  logic       err_q, err_d;
  logic       in_idle, in_req, in_rsp;

  assign in_idle = (st_q == ST_IDLE);
  assign in_req  = (st_q == ST_REQ);
  assign in_rsp  = (st_q == ST_RSP);

  always_comb begin
    st_d    = st_q;
    capture = in_idle && evt_valid && q_enable && !q_full;
    adv     = in_rsp && rsp_valid && !rsp_err;
    irq_d   = adv && q_empty;
    err_d   = in_rsp && rsp_valid && rsp_err;
    unique case (st_q)
      ST_IDLE: if (capture)   st_d = ST_REQ;
      ST_REQ:  if (req_ready) st_d = ST_RSP;
      ST_RSP:  if (rsp_valid) st_d = ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= irq_d;
      err_q <= err_d;
    end
  end

  assign evt_ready = in_idle;
  assign req_valid = in_req;
  assign irq_pulse = irq_q;
  assign err_pulse = err_q;
endmodule

// File: rtl/evq_producer.sv
module evq_producer #(
  parameter int ADDR_W     = 32,
  parameter int REC_W      = 64,
  parameter int LOG2SIZE   = 3,
  parameter int ENTRY_LOG2 = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_enable,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic [LOG2SIZE:0]   cons_idx,
  input  logic                evt_valid,
  output logic                evt_ready,
  input  logic [REC_W-1:0]    evt_data,
  output logic                wr_req_valid,
  input  logic                wr_req_ready,
  output logic [ADDR_W-1:0]   wr_req_addr,
  output logic [REC_W-1:0]    wr_req_data,
  input  logic                wr_rsp_valid,
  input  logic                wr_rsp_err,
  output logic [LOG2SIZE:0]   prod_idx,
  output logic                irq_pulse,
  output logic                wr_err_pulse
);
  logic              rst_int_n;
  logic              capture, adv, q_empty, q_full;
  logic [ADDR_W-1:0] slot_addr;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [REC_W-1:0]  data_q, data_d;

  evq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  evq_ptr #(.LOG2SIZE(LOG2SIZE)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .adv      (adv),
    .cons_idx (cons_idx),
    .prod_idx (prod_idx),
    .q_empty  (q_empty),
    .q_full   (q_full)
  );

  evq_addr_gen #(
    .ADDR_W     (ADDR_W),
    .LOG2SIZE   (LOG2SIZE),
    .ENTRY_LOG2 (ENTRY_LOG2)
  ) u_addr (
    .base (cfg_base),
    .slot (prod_idx[LOG2SIZE-1:0]),
    .addr (slot_addr)
  );

  evq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .evt_valid (evt_valid),
    .q_enable  (cfg_enable),
    .q_full    (q_full),
    .q_empty   (q_empty),
    .req_ready (wr_req_ready),
    .rsp_valid (wr_rsp_valid),
    .rsp_err   (wr_rsp_err),
    .evt_ready (evt_ready),
    .capture   (capture),
    .req_valid (wr_req_valid),
    .adv       (adv),
    .irq_pulse (irq_pulse),
    .err_pulse (wr_err_pulse)
  );

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    if (capture) begin
      addr_d = slot_addr;
      data_d = evt_data;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (capture) begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_req_addr = addr_q;
  assign wr_req_data = data_q;
endmodule

// File: rtl/evq_producer_chk.sv
module evq_producer_chk #(
  parameter int ADDR_W   = 32,
  parameter int LOG2SIZE = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic [LOG2SIZE:0] cons_idx,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic              wr_req_valid,
  input logic              wr_req_ready,
  input logic [ADDR_W-1:0] wr_req_addr,
  input logic              wr_rsp_valid,
  input logic              wr_rsp_err,
  input logic [LOG2SIZE:0] prod_idx,
  input logic              irq_pulse,
  input logic              wr_err_pulse
);
  // R2
  disabled_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready && !cfg_enable) |=> !wr_req_valid);

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready &&
     (prod_idx[LOG2SIZE-1:0] == cons_idx[LOG2SIZE-1:0]) &&
     (prod_idx[LOG2SIZE] != cons_idx[LOG2SIZE])) |=> !wr_req_valid);

  // R5
  idx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_rsp_valid && !wr_rsp_err) |=> $stable(prod_idx));

  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err_pulse |-> $stable(prod_idx));

  // R7
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_valid |-> !evt_ready);

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_valid && !wr_req_ready) |=> (wr_req_valid && $stable(wr_req_addr)));
endmodule

bind evq_producer evq_producer_chk #(
  .ADDR_W   (ADDR_W),
  .LOG2SIZE (LOG2SIZE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_enable   (cfg_enable),
  .cons_idx     (cons_idx),
  .evt_valid    (evt_valid),
  .evt_ready    (evt_ready),
  .wr_req_valid (wr_req_valid),
  .wr_req_ready (wr_req_ready),
  .wr_req_addr  (wr_req_addr),
  .wr_rsp_valid (wr_rsp_valid),
  .wr_rsp_err   (wr_rsp_err),
  .prod_idx     (prod_idx),
  .irq_pulse    (irq_pulse),
  .wr_err_pulse (wr_err_pulse)
);

// File: tb/tb_evq_producer.sv
module tb_evq_producer;
  localparam int ADDR_W = 32;
  localparam int REC_W  = 64;
  localparam int L2S    = 3;
  localparam int ELOG2  = 5;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [REC_W-1:0]  data;
  } wr_item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_enable = 1'b0;
  logic [ADDR_W-1:0] cfg_base = 32'h8000_1000;
  logic [L2S:0]      cons_idx = '0;
  logic              evt_valid = 1'b0;
  logic              evt_ready;
  logic [REC_W-1:0]  evt_data = '0;
  logic              wr_req_valid;
  logic              wr_req_ready = 1'b1;
  logic [ADDR_W-1:0] wr_req_addr;
  logic [REC_W-1:0]  wr_req_data;
  logic              wr_rsp_valid = 1'b0;
  logic              wr_rsp_err = 1'b0;
  logic [L2S:0]      prod_idx;
  logic              irq_pulse;
  logic              wr_err_pulse;

  int n_chk = 0;
  int n_fail = 0;
  int req_cnt = 0;
  int irq_cnt = 0;
  int err_cnt = 0;
  bit fail_next = 1'b0;
  bit irq_prev = 1'b0;
  logic [L2S:0] m_prod = '0;
  wr_item_t exp_q[$];

  always #4 clk = ~clk;

  evq_producer #(
    .ADDR_W(ADDR_W), .REC_W(REC_W), .LOG2SIZE(L2S), .ENTRY_LOG2(ELOG2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_base(cfg_base),
    .cons_idx(cons_idx), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_data(evt_data), .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
    .wr_req_addr(wr_req_addr), .wr_req_data(wr_req_data),
    .wr_rsp_valid(wr_rsp_valid), .wr_rsp_err(wr_rsp_err), .prod_idx(prod_idx),
    .irq_pulse(irq_pulse), .wr_err_pulse(wr_err_pulse)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [L2S:0] p);
    return cfg_base + ADDR_W'(p[L2S-1:0]) * (ADDR_W'(1) << ELOG2);
  endfunction

  // memory model and monitor: one-cycle response, scoreboard compare
  always @(posedge clk) begin
    wr_rsp_valid <= wr_req_valid && wr_req_ready;
    wr_rsp_err   <= fail_next;
    if (wr_req_valid && wr_req_ready) begin
      req_cnt++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "unexpected write addr", wr_req_addr, 0);
      end else begin
        wr_item_t e;
        e = exp_q.pop_front();
        check(wr_req_addr == e.addr, "R4", "write address", wr_req_addr, e.addr);
        check(wr_req_data == e.data, "R4", "write data", wr_req_data, e.data);
      end
    end
    if (irq_pulse) irq_cnt++;
    if (wr_err_pulse) err_cnt++;
    if (irq_pulse && irq_prev)
      check(1'b0, "R8", "irq pulse width >1", 2, 1);
    irq_prev = irq_pulse;
  end

  // driver: offer one event; push the expected write when one is due
  task automatic send(input logic [REC_W-1:0] d, input bit expect_wr);
    while (!evt_ready) @(negedge clk);
    if (expect_wr) exp_q.push_back('{slot_addr(m_prod), d});
    evt_valid = 1'b1;
    evt_data  = d;
    @(negedge clk);
    evt_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check(1'b0, "WDOG", "run did not finish", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int irq0, req0, err0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(evt_ready == 1'b1, "R1", "evt_ready", evt_ready, 1);
    check(prod_idx == '0, "R1", "prod_idx", prod_idx, 0);
    check(wr_req_valid == 1'b0 && irq_pulse == 1'b0 && wr_err_pulse == 1'b0,
          "R1", "outputs idle", {wr_req_valid, irq_pulse, wr_err_pulse}, 0);

    // R2 disabled queue drops the event
    send(64'hDEAD_0000_0000_0001, 1'b0);
    check(prod_idx == '0, "R2", "prod_idx after drop", prod_idx, 0);
    check(req_cnt == 0, "R2", "requests after drop", req_cnt, 0);

    // R8 first write into empty queue fires the interrupt
    cfg_enable = 1'b1;
    irq0 = irq_cnt;
    send(64'h1111_0000_0000_0000, 1'b1);
    m_prod++;
    check(prod_idx == m_prod, "R5", "prod_idx after ok write", prod_idx, m_prod);
    check(irq_cnt == irq0 + 1, "R8", "irq on empty->non-empty", irq_cnt, irq0 + 1);

    // R4 fill further slots, no more interrupts
    for (int i = 1; i < 7; i++) begin
      send(64'h2222_0000_0000_0000 + 64'(i), 1'b1);
      m_prod++;
    end
    check(irq_cnt == irq0 + 1, "R8", "no irq while non-empty", irq_cnt, irq0 + 1);
    check(prod_idx == 4'd7, "R4", "prod_idx after 7 writes", prod_idx, 7);

    // R6 last slot wraps index to 0 and sets wrap bit
    send(64'h3333_0000_0000_0007, 1'b1);
    m_prod++;
    check(prod_idx == 4'b1000, "R6", "wrap toggle", prod_idx, 4'b1000);

    // R3 full queue drops
    req0 = req_cnt;
    send(64'h4444_0000_0000_0000, 1'b0);
    check(prod_idx == 4'b1000, "R3", "prod_idx when full", prod_idx, 4'b1000);
    check(req_cnt == req0, "R3", "no request when full", req_cnt, req0);

    // R3 consumer moves: not full any more, write slot 0
    cons_idx = 4'b0100;
    send(64'h5555_0000_0000_0000, 1'b1);
    m_prod++;
    check(prod_idx == 4'b1001, "R3", "write after space freed", prod_idx, 4'b1001);

    // R5 failed write: index stays, error pulse, retry same slot
    err0 = err_cnt;
    fail_next = 1'b1;
    send(64'h6666_0000_0000_0000, 1'b1);
    fail_next = 1'b0;
    check(prod_idx == 4'b1001, "R5", "prod_idx after error", prod_idx, 4'b1001);
    check(err_cnt == err0 + 1, "R5", "error pulse count", err_cnt, err0 + 1);
    send(64'h6666_0000_0000_0001, 1'b1);
    m_prod++;
    check(prod_idx == 4'b1010, "R5", "retry advances", prod_idx, 4'b1010);

    // R8 drain queue, next write interrupts again
    cons_idx = m_prod;
    irq0 = irq_cnt;
    send(64'h7777_0000_0000_0000, 1'b1);
    m_prod++;
    check(irq_cnt == irq0 + 1, "R8", "irq after drain", irq_cnt, irq0 + 1);

    // R7 / R9 stalled request port
    wr_req_ready = 1'b0;
    while (!evt_ready) @(negedge clk);
    exp_q.push_back('{slot_addr(m_prod), 64'h8888_0000_0000_0000});
    evt_valid = 1'b1;
    evt_data  = 64'h8888_0000_0000_0000;
    @(negedge clk);
    evt_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(evt_ready == 1'b0, "R7", "ready low while outstanding", evt_ready, 0);
    check(wr_req_valid == 1'b1, "R9", "request held", wr_req_valid, 1);
    check(wr_req_addr == slot_addr(m_prod), "R9", "address held",
          wr_req_addr, slot_addr(m_prod));
    wr_req_ready = 1'b1;
    repeat (4) @(negedge clk);
    m_prod++;
    check(evt_ready == 1'b1, "R7", "ready back after response", evt_ready, 1);
    check(prod_idx == m_prod, "R5", "prod_idx after stalled write", prod_idx, m_prod);

    check(exp_q.size() == 0, "R4", "all expected writes seen", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule